// File: doc/BRIEF.md
# Push-All Register Stack Sequencer

This block performs one "store every general-purpose register on the stack" operation for a core that runs with 16-bit or 32-bit operands. A strobe on `start` captures the operand width, the execution mode, the lock-prefix flag, the privilege level, the alignment-check enable, the stack segment limit and all eight register values. One cycle later the block decides, before touching memory, whether the operation is legal in the captured mode. If it is legal, the block issues eight ordered stack writes on a valid/ready write port and then reports completion together with the new stack pointer. If it is not legal, it reports a fault code and makes no write.

The stack pointer stored by the operation is the value captured at the start, not the value it has been decremented to by the time its slot comes up. Each write first moves the working pointer down by the operand width and then stores at the new address. A memory-side abort on the write port ends the sequence with its own fault code. One real-mode case (a starting pointer of 1, 3 or 5) is reported as a double fault, and the block then stays in a shutdown state until reset.

The controller has six states. IDLE waits for `start` and captures the inputs (IDLE to CHECK). CHECK evaluates legality for one cycle. It goes to PUSH when legal and to REPORT otherwise. PUSH presents one write per cycle and advances on each accepted write. After the eighth acceptance it goes to DONE. On `wr_abort` it goes to REPORT. DONE pulses `done` for one cycle and returns to IDLE. REPORT pulses `fault_valid` for one cycle. It returns to IDLE, except for a double fault, where it goes to HALT. HALT asserts `shutdown`, ignores `start` and is left only through reset.

Top module: `pushall_seq`

## Requirements
- R1: Registers are written in slot order 0 to 7: accumulator, counter, data, base, stack pointer, base pointer, source index, destination index. In `gpr_in`, slot k occupies bits [32k+31:32k].
- R2: The value written for slot 4 is the stack pointer captured at `start`, not the working pointer at the time of that write.
- R3: With `op32`=1 each write carries the full 32-bit register, `wr_wide`=1 and a step of 4. With `op32`=0 it carries the low 16 bits zero-extended, `wr_wide`=0 and a step of 2.
- R4: Write k (k=0..7) goes to address start_sp − step×(k+1). In the cycle after the eighth accepted write, `done` is 1 for one cycle and `sp_out` equals start_sp − 8×step.
- R5: When `lock_pfx` is set, the operation faults with code 1 (invalid opcode) in every mode and makes no write.
- R6: In mode 4 (64-bit), the operation faults with code 1 and makes no write. Mode encoding: 0 real, 1 virtual-8086, 2 protected, 3 compatibility, 4 64-bit.
- R7: In modes 0 and 1, a start stack pointer of 7, 9, 11, 13 or 15 faults with code 2 (general protection) and makes no write.
- R8: In mode 0, a start stack pointer of 1, 3 or 5 reports code 5 (double fault) and makes no write. After that `shutdown` stays 1 and `start` is ignored until reset.
- R9: In modes 2 and 3, code 3 (stack fault) is reported when the first address (sp − step) or the last address (sp − 8×step, modulo 2^32) is above `seg_limit`.
- R10: Code 4 (alignment) is reported for an unaligned start pointer (low two bits nonzero for 32-bit, bit 0 set for 16-bit) in two cases: in modes 2 and 3 when `cpl`=3 and `align_chk_en`=1, and in mode 1 whenever `align_chk_en`=1. A stack fault takes priority over an alignment fault.
- R11: The first write, or `fault_valid`, appears in the second cycle after `start`. A write that has not been accepted keeps its address and data stable. Exactly one write is accepted per cycle in which `wr_valid` and `wr_ready` are both high.
- R12: `wr_abort` during PUSH ends the sequence with code 6 and no further writes. While `fault_valid` is high, `sp_out` shows the start pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one operation (sampled in IDLE) |
| op32 | input | 1 | 1 = 32-bit operands, 0 = 16-bit |
| exec_mode | input | 3 | Execution mode code |
| lock_pfx | input | 1 | Lock prefix present |
| cpl | input | 2 | Current privilege level |
| align_chk_en | input | 1 | Alignment checking enabled |
| seg_limit | input | 32 | Stack segment limit |
| gpr_in | input | 256 | Eight register values, slot k at bits [32k+31:32k] |
| wr_valid | output | 1 | Stack write request |
| wr_ready | input | 1 | Memory accepts the write |
| wr_abort | input | 1 | Memory-side abort of the sequence |
| wr_addr | output | 32 | Write address |
| wr_data | output | 32 | Write data |
| wr_wide | output | 1 | 1 = 4-byte write, 0 = 2-byte write |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| fault_valid | output | 1 | One-cycle fault pulse |
| fault_code | output | 3 | 0 none, 1 invalid opcode, 2 general protection, 3 stack, 4 alignment, 5 double fault, 6 abort |
| sp_out | output | 32 | Final pointer when done, start pointer otherwise |
| shutdown | output | 1 | Held after a double fault |

## Verification
The bench checks the stack-pointer slot against the captured start value. A design that stored the decremented pointer would write start−16 or start−8 there. It checks 16-bit runs under a stalling ready pattern, which exposes a step of 4 or a dropped or repeated write. It targets the segment-limit check at both ends, including a start pointer small enough for the last address to wrap. A design that tested only the first address would then write instead of faulting. It covers alignment faults in protected mode at privilege 3 and 0, and in virtual-8086 mode, and the double-fault path. A design that left the shutdown state would answer a later `start`.

// File: rtl/pushall_pkg.sv
package pushall_pkg;

    typedef enum logic [2:0] {
        MODE_REAL   = 3'd0,
        MODE_V86    = 3'd1,
        MODE_PROT   = 3'd2,
        MODE_COMPAT = 3'd3,
        MODE_LONG   = 3'd4
    } exec_mode_e;

    typedef enum logic [2:0] {
        FLT_NONE  = 3'd0,
        FLT_UD    = 3'd1,
        FLT_GP    = 3'd2,
        FLT_SS    = 3'd3,
        FLT_AC    = 3'd4,
        FLT_DF    = 3'd5,
        FLT_ABORT = 3'd6
    } fault_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_CHECK  = 3'd1,
        ST_PUSH   = 3'd2,
        ST_REPORT = 3'd3,
        ST_DONE   = 3'd4,
        ST_HALT   = 3'd5
    } state_e;

endpackage

// File: rtl/pushall_legality.sv
module pushall_legality
    import pushall_pkg::*;
#(
    parameter int WORD_W   = 32,
    parameter int NUM_REGS = 8
) (
    input  logic [2:0]        mode,
    input  logic              wide,
    input  logic              lock,
    input  logic [1:0]        cpl,
    input  logic              ac_en,
    input  logic [WORD_W-1:0] limit,
    input  logic [WORD_W-1:0] sp,
    output fault_e            code
);
    logic [WORD_W-1:0] step;
    logic [WORD_W-1:0] span;
    logic [WORD_W-1:0] first_addr;
    logic [WORD_W-1:0] last_addr;
    logic              unaligned;
    logic              gp_sp;
    logic              df_sp;
    logic              segmented;
    logic              ss_hit;
    logic              ac_hit;

    always_comb begin
        step       = wide ? WORD_W'(4) : WORD_W'(2);
        span       = step * WORD_W'(NUM_REGS);
        first_addr = sp - step;
        last_addr  = sp - span;
        unaligned  = wide ? (sp[1:0] != 2'b00) : sp[0];
        gp_sp      = (sp == WORD_W'(7))  || (sp == WORD_W'(9)) ||
                     (sp == WORD_W'(11)) || (sp == WORD_W'(13)) ||
                     (sp == WORD_W'(15));
        df_sp      = (sp == WORD_W'(1)) || (sp == WORD_W'(3)) ||
                     (sp == WORD_W'(5));
        segmented  = (mode == MODE_PROT) || (mode == MODE_COMPAT);
        ss_hit     = (first_addr > limit) || (last_addr > limit);
        ac_hit     = unaligned && ac_en &&
                     ((segmented && cpl == 2'd3) || (mode == MODE_V86));
    end

    always_comb begin
        code = FLT_NONE;
        if (lock || mode == MODE_LONG) begin
            code = FLT_UD;
        end else if ((mode == MODE_REAL || mode == MODE_V86) && gp_sp) begin
            code = FLT_GP;
        end else if (mode == MODE_REAL && df_sp) begin
            code = FLT_DF;
        end else if (segmented && ss_hit) begin
            code = FLT_SS;
        end else if (ac_hit) begin
            code = FLT_AC;
        end
    end

endmodule

// File: rtl/pushall_slot_mux.sv
module pushall_slot_mux #(
    parameter int WORD_W   = 32,
    parameter int NUM_REGS = 8,
    parameter int SP_SLOT  = 4,
    parameter int IDX_W    = 3
) (
    input  logic [NUM_REGS*WORD_W-1:0] regs,
    input  logic [WORD_W-1:0]          snap_sp,
    input  logic [IDX_W-1:0]           sel,
    input  logic                       wide,
    output logic [WORD_W-1:0]          data
);
    localparam int HALF_W = WORD_W / 2;

    logic [WORD_W-1:0] slot [NUM_REGS];
    logic [WORD_W-1:0] picked;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
        if (g == SP_SLOT) begin : g_snap
            assign slot[g] = snap_sp;
        end else begin : g_reg
            assign slot[g] = regs[g*WORD_W +: WORD_W];
        end
    end

    always_comb begin
        picked = slot[sel];
        data   = wide ? picked : {{(WORD_W-HALF_W){1'b0}}, picked[HALF_W-1:0]};
    end

endmodule

// File: rtl/pushall_seq.sv
module pushall_seq
    import pushall_pkg::*;
#(
    parameter int WORD_W   = 32,
    parameter int NUM_REGS = 8,
    parameter int SP_SLOT  = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic                       op32,
    input  logic [2:0]                 exec_mode,
    input  logic                       lock_pfx,
    input  logic [1:0]                 cpl,
    input  logic                       align_chk_en,
    input  logic [WORD_W-1:0]          seg_limit,
    input  logic [NUM_REGS*WORD_W-1:0] gpr_in,
    output logic                       wr_valid,
    input  logic                       wr_ready,
    input  logic                       wr_abort,
    output logic [WORD_W-1:0]          wr_addr,
    output logic [WORD_W-1:0]          wr_data,
    output logic                       wr_wide,
    output logic                       busy,
    output logic                       done,
    output logic                       fault_valid,
    output logic [2:0]                 fault_code,
    output logic [WORD_W-1:0]          sp_out,
    output logic                       shutdown
);
    localparam int IDX_W = $clog2(NUM_REGS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REGS - 1);

    state_e                     state_q, state_d;
    logic                       wide_q;
    logic [2:0]                 mode_q;
    logic                       lock_q;
    logic [1:0]                 cpl_q;
    logic                       ac_q;
    logic [WORD_W-1:0]          limit_q;
    logic [NUM_REGS*WORD_W-1:0] gpr_q;
    logic [WORD_W-1:0]          work_sp_q;
    logic [IDX_W-1:0]           idx_q;
    fault_e                     code_q;

    fault_e                     chk_code;
    logic [WORD_W-1:0]          snap_sp;
    logic [WORD_W-1:0]          step;
    logic [WORD_W-1:0]          mux_data;
    logic                       accept;

    assign snap_sp = gpr_q[SP_SLOT*WORD_W +: WORD_W];
    assign step    = wide_q ? WORD_W'(4) : WORD_W'(2);
    assign accept  = (state_q == ST_PUSH) && wr_ready && !wr_abort;

    pushall_legality #(
        .WORD_W   (WORD_W),
        .NUM_REGS (NUM_REGS)
    ) u_legality (
        .mode  (mode_q),
        .wide  (wide_q),
        .lock  (lock_q),
        .cpl   (cpl_q),
        .ac_en (ac_q),
        .limit (limit_q),
        .sp    (snap_sp),
        .code  (chk_code)
    );

    pushall_slot_mux #(
        .WORD_W   (WORD_W),
        .NUM_REGS (NUM_REGS),
        .SP_SLOT  (SP_SLOT),
        .IDX_W    (IDX_W)
    ) u_slot_mux (
        .regs    (gpr_q),
        .snap_sp (snap_sp),
        .sel     (idx_q),
        .wide    (wide_q),
        .data    (mux_data)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_CHECK;
            ST_CHECK:  state_d = (chk_code == FLT_NONE) ? ST_PUSH : ST_REPORT;
            ST_PUSH: begin
                if (wr_abort) begin
                    state_d = ST_REPORT;
                end else if (wr_ready && idx_q == LAST_IDX) begin
                    state_d = ST_DONE;
                end
            end
            ST_REPORT: state_d = (code_q == FLT_DF) ? ST_HALT : ST_IDLE;
            ST_DONE:   state_d = ST_IDLE;
            ST_HALT:   state_d = ST_HALT;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            wide_q    <= 1'b0;
            mode_q    <= 3'd0;
            lock_q    <= 1'b0;
            cpl_q     <= 2'd0;
            ac_q      <= 1'b0;
            limit_q   <= '0;
            gpr_q     <= '0;
            work_sp_q <= '0;
            idx_q     <= '0;
            code_q    <= FLT_NONE;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        wide_q    <= op32;
                        mode_q    <= exec_mode;
                        lock_q    <= lock_pfx;
                        cpl_q     <= cpl;
                        ac_q      <= align_chk_en;
                        limit_q   <= seg_limit;
                        gpr_q     <= gpr_in;
                        work_sp_q <= gpr_in[SP_SLOT*WORD_W +: WORD_W];
                        idx_q     <= '0;
                        code_q    <= FLT_NONE;
                    end
                end
                ST_CHECK: code_q <= chk_code;
                ST_PUSH: begin
                    if (wr_abort) begin
                        code_q <= FLT_ABORT;
                    end else if (wr_ready) begin
                        work_sp_q <= work_sp_q - step;
                        idx_q     <= idx_q + 1'b1;
                    end
                end
                ST_REPORT, ST_DONE, ST_HALT: ;
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        wr_valid    = 1'b0;
        done        = 1'b0;
        fault_valid = 1'b0;
        shutdown    = 1'b0;
        busy        = 1'b1;
        fault_code  = FLT_NONE;
        sp_out      = snap_sp;
        unique case (state_q)
            ST_IDLE:   busy = 1'b0;
            ST_CHECK:  ;
            ST_PUSH:   wr_valid = 1'b1;
            ST_REPORT: begin
                fault_valid = 1'b1;
                fault_code  = code_q;
            end
            ST_DONE: begin
                done   = 1'b1;
                sp_out = work_sp_q;
            end
            ST_HALT: begin
                busy       = 1'b0;
                shutdown   = 1'b1;
                fault_code = code_q;
            end
            default: busy = 1'b0;
        endcase
        wr_addr = work_sp_q - step;
        wr_data = mux_data;
        wr_wide = wide_q;
    end

    // Assertions
    a_r11_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready && !wr_abort) |=>
        (wr_valid && $stable(wr_addr) && $stable(wr_data)));

    a_r4_addr_steps_down: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && idx_q != LAST_IDX) |=>
        (wr_valid && wr_addr == $past(wr_addr) - (wr_wide ? WORD_W'(4) : WORD_W'(2))));

    a_r4_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && idx_q == LAST_IDX) |=> (done && !wr_valid));

    a_r6_long_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CHECK && mode_q == MODE_LONG) |=>
        (fault_valid && fault_code == FLT_UD && !wr_valid));

    a_r5_lock_ud: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CHECK && lock_q) |=> (fault_valid && fault_code == FLT_UD));

    a_r8_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown |=> (shutdown && !wr_valid));

    a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_valid, done, fault_valid, shutdown}));

    a_r12_abort_reports: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_abort) |=> (fault_valid && fault_code == FLT_ABORT));

endmodule

// File: tb/pushall_seq_bench.sv
module pushall_seq_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         op32 = 1'b0;
    logic [2:0]   exec_mode = 3'd0;
    logic         lock_pfx = 1'b0;
    logic [1:0]   cpl = 2'd0;
    logic         align_chk_en = 1'b0;
    logic [31:0]  seg_limit = 32'hFFFF_FFFF;
    logic [255:0] gpr_in = '0;
    logic         wr_valid, wr_ready = 1'b0, wr_abort = 1'b0;
    logic [31:0]  wr_addr, wr_data, sp_out;
    logic         wr_wide, busy, done, fault_valid, shutdown;
    logic [2:0]   fault_code;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    pushall_seq u_pushall_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .op32(op32),
        .exec_mode(exec_mode), .lock_pfx(lock_pfx), .cpl(cpl),
        .align_chk_en(align_chk_en), .seg_limit(seg_limit), .gpr_in(gpr_in),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_abort(wr_abort),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_wide(wr_wide),
        .busy(busy), .done(done), .fault_valid(fault_valid),
        .fault_code(fault_code), .sp_out(sp_out), .shutdown(shutdown)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] reg_val(input int k, input logic [31:0] sp);
        if (k == 4) return sp;
        return 32'hA5C3_1234 + 32'h0102_0408 * k;
    endfunction

    task automatic launch(input logic w, input logic [2:0] m, input logic lk,
                          input logic [1:0] c, input logic ac,
                          input logic [31:0] lim, input logic [31:0] sp);
        @(negedge clk);
        op32 = w; exec_mode = m; lock_pfx = lk; cpl = c; align_chk_en = ac;
        seg_limit = lim;
        for (int k = 0; k < 8; k++) gpr_in[k*32 +: 32] = reg_val(k, sp);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        gpr_in = '0;
    endtask

    // R1 R2 R3 R4 R11: full push with optional stalls
    task automatic run_push(input string tag, input logic w, input logic [2:0] m,
                            input logic [1:0] c, input logic ac,
                            input logic [31:0] lim, input logic [31:0] sp,
                            input bit stall);
        int k = 0;
        int cyc = 0;
        bit ok_all = 1'b1;
        logic [31:0] step = w ? 32'd4 : 32'd2;
        logic [31:0] ea, ed;
        launch(w, m, 1'b0, c, ac, lim, sp);
        check(!wr_valid && busy, {tag, " R11 no write in check cycle"}, {31'd0, wr_valid}, 32'd0);
        while (k < 8 && cyc < 80) begin
            wr_ready = stall ? (cyc % 3 != 1) : 1'b1;
            #1;
            if (wr_valid && wr_ready) begin
                ea = sp - step * (k + 1);
                ed = w ? reg_val(k, sp) : {16'h0, reg_val(k, sp)[15:0]};
                if (wr_addr !== ea || wr_data !== ed || wr_wide !== w) begin
                    ok_all = 1'b0;
                    check(1'b0, $sformatf("%s R1 R2 R3 write %0d addr", tag, k), wr_addr, ea);
                    check(1'b0, $sformatf("%s R1 R2 R3 write %0d data", tag, k), wr_data, ed);
                end
                k++;
            end
            @(negedge clk);
            cyc++;
        end
        wr_ready = 1'b0;
        check(ok_all && k == 8, {tag, " R1 R3 eight ordered writes"}, k, 8);
        check(done === 1'b1, {tag, " R4 done pulse"}, {31'd0, done}, 32'd1);
        check(sp_out === sp - 8 * step, {tag, " R4 final sp"}, sp_out, sp - 8 * step);
        @(negedge clk);
        check(!done && !busy, {tag, " R4 back to idle"}, {31'd0, done}, 32'd0);
    endtask

    // R5 R6 R7 R8 R9 R10: fault with no writes
    task automatic run_fault(input string tag, input logic w, input logic [2:0] m,
                             input logic lk, input logic [1:0] c, input logic ac,
                             input logic [31:0] lim, input logic [31:0] sp,
                             input logic [2:0] exp_code);
        bit wrote = 1'b0;
        launch(w, m, lk, c, ac, lim, sp);
        wr_ready = 1'b1;
        if (wr_valid) wrote = 1'b1;
        @(negedge clk);
        check(fault_valid === 1'b1 && fault_code === exp_code, {tag, " fault code"},
              {29'd0, fault_code}, {29'd0, exp_code});
        check(sp_out === sp, {tag, " R12 sp unchanged on fault"}, sp_out, sp);
        for (int i = 0; i < 3; i++) begin
            if (wr_valid) wrote = 1'b1;
            @(negedge clk);
        end
        wr_ready = 1'b0;
        check(!wrote, {tag, " no stack write"}, {31'd0, wrote}, 32'd0);
    endtask

    // R12: abort part-way through
    task automatic run_abort();
        int k = 0;
        bit wrote_after = 1'b0;
        launch(1'b1, 3'd2, 1'b0, 2'd0, 1'b0, 32'hFFFF_FFFF, 32'h0000_4000);
        wr_ready = 1'b1;
        @(negedge clk);
        while (k < 3) begin
            if (wr_valid) k++;
            @(negedge clk);
        end
        wr_abort = 1'b1;
        @(negedge clk);
        wr_abort = 1'b0;
        check(fault_valid && fault_code == 3'd6, "R12 abort code", {29'd0, fault_code}, 32'd6);
        check(sp_out === 32'h0000_4000, "R12 abort sp", sp_out, 32'h0000_4000);
        for (int i = 0; i < 3; i++) begin
            if (wr_valid) wrote_after = 1'b1;
            @(negedge clk);
        end
        wr_ready = 1'b0;
        check(!wrote_after && !busy, "R12 no writes after abort", {31'd0, wrote_after}, 32'd0);
    endtask

    // R8: double fault then shutdown hold
    task automatic run_shutdown();
        run_fault("R8 real sp=3", 1'b0, 3'd0, 1'b0, 2'd0, 1'b0, 32'hFFFF, 32'd3, 3'd5);
        check(shutdown === 1'b1, "R8 shutdown held", {31'd0, shutdown}, 32'd1);
        launch(1'b1, 3'd2, 1'b0, 2'd0, 1'b0, 32'hFFFF_FFFF, 32'h1000);
        wr_ready = 1'b1;
        repeat (3) @(negedge clk);
        wr_ready = 1'b0;
        check(!wr_valid && !fault_valid && shutdown, "R8 start ignored in shutdown",
              {31'd0, wr_valid}, 32'd0);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!shutdown && !busy, "R8 reset leaves shutdown", {31'd0, shutdown}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!wr_valid && !busy && !done && !fault_valid && !shutdown,
              "R11 reset state", {31'd0, busy}, 32'd0);

        run_push("prot32", 1'b1, 3'd2, 2'd0, 1'b0, 32'hFFFF_FFFF, 32'h0000_1000, 1'b0);
        run_push("real16 stall", 1'b0, 3'd0, 2'd0, 1'b0, 32'h0000_FFFF, 32'h0000_0200, 1'b1);
        run_push("compat32 stall", 1'b1, 3'd3, 2'd3, 1'b0, 32'h0001_0000, 32'h0000_8000, 1'b1);
        run_push("R10 prot cpl0 unaligned ok", 1'b1, 3'd2, 2'd0, 1'b1, 32'hFFFF_FFFF, 32'h0000_1002, 1'b0);

        run_fault("R5 lock real", 1'b0, 3'd0, 1'b1, 2'd0, 1'b0, 32'hFFFF, 32'h100, 3'd1);
        run_fault("R5 lock prot", 1'b1, 3'd2, 1'b1, 2'd0, 1'b0, 32'hFFFF_FFFF, 32'h1000, 3'd1);
        run_fault("R6 long mode", 1'b1, 3'd4, 1'b0, 2'd0, 1'b0, 32'hFFFF_FFFF, 32'h1000, 3'd1);
        run_fault("R7 v86 sp=9", 1'b0, 3'd1, 1'b0, 2'd0, 1'b0, 32'hFFFF, 32'd9, 3'd2);
        run_fault("R7 real sp=15", 1'b1, 3'd0, 1'b0, 2'd0, 1'b0, 32'hFFFF, 32'd15, 3'd2);
        run_fault("R9 first above limit", 1'b1, 3'd2, 1'b0, 2'd0, 1'b0, 32'h0000_0FF0, 32'h1000, 3'd3);
        run_fault("R9 last wraps", 1'b1, 3'd3, 1'b0, 2'd0, 1'b0, 32'h0000_FFFF, 32'h1C, 3'd3);
        run_fault("R10 prot cpl3", 1'b1, 3'd2, 1'b0, 2'd3, 1'b1, 32'hFFFF_FFFF, 32'h1002, 3'd4);
        run_fault("R10 v86 cpl0", 1'b0, 3'd1, 1'b0, 2'd0, 1'b1, 32'hFFFF, 32'h0201, 3'd4);

        run_abort();
        run_shutdown();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule